// File: doc/BRIEF.md
# Inverting-Output Scratchpad Bit Memory

A small read/write memory of 256 one-bit words, fully decoded from an 8-bit address and gated by three active-low chip selects. The block is selected only when every select is low. While selected, the output shows the complement of the addressed bit. During a write it shows the complement of the bit being written, so the writer can confirm the value on the same access.

Timing is counted in clock cycles. A write commits on the clock edge where write enable is sampled low with the block selected. Read data appears one clock after the address. The output-enable flag models a tri-state driver and drops in the same cycle that any select goes high. A parameter switches the driver to open-drain style, in which the enable is raised only while the output is pulling low. Contents are undefined after reset.

Top module: `inv_scratch_ram`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `dout_oe` is 0.
- R2: On a clock edge with `we_n` = 0 and all three `cs_n` bits = 0, `din` is stored at `addr`.
- R3: When the block was selected with `we_n` = 1 at a clock edge, the following cycle shows `dout` = NOT(stored bit at the sampled address).
- R4: When the block was selected with `we_n` = 0 at a clock edge, the following cycle shows `dout` = NOT(the sampled `din`).
- R5: In any cycle where at least one `cs_n` bit is 1, `dout_oe` is 0 in that same cycle.
- R6: A write attempted while any `cs_n` bit is 1 leaves the memory unchanged.
- R7: In tri-state mode, `dout_oe` is 1 exactly when the block was selected at the previous edge and is still selected now.
- R8: In open-drain mode (`DRIVE` = `DRV_OPEN_DRAIN`), `dout_oe` is 1 only when `dout` is 0 and the R7 condition holds.
- R9: All 2^`ADDR_W` addresses hold independent bits, with no aliasing between locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| din | input | 1 | Write data |
| we_n | input | 1 | Write enable, active low |
| cs_n | input | NUM_CS | Chip selects, all active low |
| dout | output | 1 | Inverted read data, or inverted write data |
| dout_oe | output | 1 | Driver enable (models tri-state or open-drain) |

## Verification
On every cycle, the assertions check several properties. A deselect forces the enable off at once. A write shows its inverted data on the next cycle. A stored bit matches the last committed write. The reset and open-drain enable rules always hold. Only the bench's scenarios can show that reads return the complement of earlier writes across the whole address range, and that deselected writes leave no trace. These require a full write-then-read history, which the bench's behavioural memory model keeps.

// File: rtl/inv_ram_pkg.sv
package inv_ram_pkg;
  typedef enum logic {
    DRV_TRISTATE   = 1'b0,
    DRV_OPEN_DRAIN = 1'b1
  } drive_e;
endpackage

// File: rtl/inv_ram_sel.sv
module inv_ram_sel #(
  parameter int NUM_CS = 3
) (
  input  logic [NUM_CS-1:0] cs_n,
  input  logic              we_n,
  output logic              sel,
  output logic              wr_en
);
  always_comb begin
    sel   = ~|cs_n;
    wr_en = sel & ~we_n;
  end
endmodule

// File: rtl/inv_ram_array.sv
module inv_ram_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wdata,
  output logic              rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

  // R2
  store_commit_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (mem[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/inv_ram_out.sv
module inv_ram_out
  import inv_ram_pkg::*;
#(
  parameter drive_e DRIVE = DRV_TRISTATE
) (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic wr_en,
  input  logic din,
  input  logic rdata,
  output logic dout,
  output logic dout_oe
);
  logic sel_q, wr_q, din_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      sel_q <= sel;
      wr_q  <= wr_en;
    end
    din_q <= din;
  end

  always_comb dout = wr_q ? ~din_q : ~rdata;

  generate
    if (DRIVE == DRV_OPEN_DRAIN) begin : g_od
      always_comb dout_oe = sel_q & sel & ~dout;
    end else begin : g_ts
      always_comb dout_oe = sel_q & sel;
    end
  endgenerate
endmodule

// File: rtl/inv_scratch_ram.sv
module inv_scratch_ram
  import inv_ram_pkg::*;
#(
  parameter int     ADDR_W = 8,
  parameter int     NUM_CS = 3,
  parameter drive_e DRIVE  = DRV_TRISTATE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  input  logic              we_n,
  input  logic [NUM_CS-1:0] cs_n,
  output logic              dout,
  output logic              dout_oe
);
  logic sel, wr_en, rdata;

  inv_ram_sel #(.NUM_CS(NUM_CS)) u_sel (
    .cs_n(cs_n), .we_n(we_n), .sel(sel), .wr_en(wr_en)
  );

  inv_ram_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(din), .rdata(rdata)
  );

  inv_ram_out #(.DRIVE(DRIVE)) u_out (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .din(din),
    .rdata(rdata), .dout(dout), .dout_oe(dout_oe)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !dout_oe);

  // R5
  deselect_off_chk: assert property (@(posedge clk) disable iff (rst)
    (|cs_n) |-> !dout_oe);

  // R4
  write_echo_chk: assert property (@(posedge clk) disable iff (rst)
    (!we_n && !(|cs_n)) |=> (dout == !$past(din)));

  generate
    if (DRIVE == DRV_OPEN_DRAIN) begin : g_od_chk
      // R8
      od_low_only_chk: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> !dout);
    end else begin : g_ts_chk
      // R7
      ts_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (!(|cs_n)) |=> (dout_oe == !(|cs_n)));
    end
  endgenerate
endmodule

// File: tb/inv_scratch_ram_bench.sv
module inv_scratch_ram_bench;
  import inv_ram_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = '0;
  logic       din = 1'b0;
  logic       we_n = 1'b1;
  logic [2:0] cs_n = 3'b111;
  logic       dout, dout_oe, od_dout, od_oe;

  int tests = 0;
  int fails = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  inv_scratch_ram u_inv_scratch_ram (
    .clk(clk), .rst(rst), .addr(addr), .din(din), .we_n(we_n),
    .cs_n(cs_n), .dout(dout), .dout_oe(dout_oe)
  );

  inv_scratch_ram #(.DRIVE(DRV_OPEN_DRAIN)) u_od (
    .clk(clk), .rst(rst), .addr(addr), .din(din), .we_n(we_n),
    .cs_n(cs_n), .dout(od_dout), .dout_oe(od_oe)
  );

  // behavioural reference model
  bit m_mem [256];
  bit m_kn  [256];
  bit m_oe = 1'b0;
  bit m_data = 1'b0;
  bit m_dk = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_oe = 1'b0;
      m_dk = 1'b0;
    end else begin
      m_oe = (cs_n == 3'b000);
      if (cs_n == 3'b000 && !we_n) begin
        m_data = !din;
        m_dk = 1'b1;
        m_mem[addr] = din;
        m_kn[addr] = 1'b1;
      end else if (cs_n == 3'b000) begin
        m_data = !m_mem[addr];
        m_dk = m_kn[addr];
      end else begin
        m_dk = 1'b0;
      end
    end
  end

  task automatic check(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit eoe;
    eoe = m_oe && (cs_n == 3'b000);
    check(tag, dout_oe, eoe);
    if (eoe && m_dk) check(tag, dout, m_data);
    if (m_dk || !eoe) check("R8", od_oe, eoe && !m_data);
  end

  task automatic drive(logic [7:0] a, logic d, logic w, logic [2:0] c);
    @(posedge clk);
    #1;
    addr = a; din = d; we_n = w; cs_n = c;
  endtask

  function automatic bit pat(int a, int s);
    return bit'(((a >> s) ^ (a >> 3) ^ (a >> 7)) & 1);
  endfunction

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    drive(8'h00, 1'b0, 1'b1, 3'b111);
    // R9 / R2 / R4: fill every location
    tag = "R4";
    for (int a = 0; a < 256; a++) drive(a[7:0], pat(a, 0), 1'b0, 3'b000);
    // R3 / R9: read everything back
    tag = "R9";
    for (int a = 0; a < 256; a++) drive(a[7:0], 1'b0, 1'b1, 3'b000);
    // R2: overwrite with a different pattern, then read
    tag = "R2";
    for (int a = 0; a < 256; a += 5) drive(a[7:0], pat(a, 1), 1'b0, 3'b000);
    tag = "R3";
    for (int a = 0; a < 256; a++) drive(a[7:0], 1'b0, 1'b1, 3'b000);
    // R6: writes with one select high, inverting data
    tag = "R6";
    for (int a = 0; a < 48; a++)
      drive(a[7:0], !m_mem[a], 1'b0, 3'b001 << (a % 3));
    for (int a = 0; a < 48; a++) drive(a[7:0], 1'b0, 1'b1, 3'b000);
    // R5 / R7: toggle individual selects during reads
    tag = "R5";
    for (int a = 0; a < 24; a++) begin
      drive(a[7:0], 1'b0, 1'b1, 3'b000);
      drive(a[7:0], 1'b0, 1'b1, 3'b001 << (a % 3));
      tag = "R7";
      drive(a[7:0], 1'b0, 1'b1, 3'b000);
      drive(a[7:0], 1'b0, 1'b1, 3'b000);
      tag = "R5";
    end
    // R1: reset again mid-stream
    tag = "R1";
    @(posedge clk);
    #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    drive(8'h10, 1'b0, 1'b1, 3'b000);
    drive(8'h10, 1'b0, 1'b1, 3'b000);
    @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule